// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes one received Ethernet frame at a time, presented as a byte stream with first-byte and last-byte markers, and stores it into a circular region of a byte-addressed packet memory. The region is divided into 256-byte pages. It is bounded by a start page and a stop page, where the stop page is one past the last usable page. A boundary page marks the oldest page that software has not yet released. A current page marks where the next frame goes.

When the first byte of a frame arrives, the block decides whether to take the frame. It refuses the frame if the receiver is halted, if the ring is badly configured, or if the free room is less than one frame of the largest allowed size plus its checksum. An accepted frame is written byte by byte starting four bytes into the current page, wrapping from the stop page back to the start page. Short frames are zero-padded and overlong frames are truncated. The block then fills in a four-byte header at the front of the first page. The header holds a status byte, the page number where the following frame will start, and the stored length. Finally it advances the current page and raises a one-cycle completion pulse.

The host side programs the page registers and drains the ring. It moves the boundary page forward as it consumes frames, and it can load the current page directly.

Top module: `rx_ring_writer`

## Requirements
- R1: While `halted` is high when a frame's first byte arrives, the frame is refused: no memory write, no `rx_done`, `cur_pg` unchanged.
- R2: When `stop_pg` is not greater than `start_pg`, every frame is refused.
- R3: Free pages are `bound_pg - cur_pg` when `cur_pg < bound_pg`, otherwise `(stop_pg - start_pg) - (cur_pg - bound_pg)`. A frame is refused when free pages times 256 is below 1518 bytes, so 5 free pages refuse and 6 accept.
- R4: Frame byte k of an accepted frame is written to address `cur_pg*256 + 4 + k`. Writes are one per accepted input beat and are registered, so the write appears on the cycle after the beat. An address that steps onto `stop_pg*256` continues at `start_pg*256`.
- R5: A frame of fewer than 60 bytes, including a single-beat frame with both markers set, is followed by zero bytes written one per cycle until 60 bytes are stored.
- R6: After the data and the padding, four header bytes are written to `cur_pg*256 + 0..3` in this order: status, next page, length low byte, length high byte. The length is the stored byte count plus 4.
- R7: The next page is `(cur_pg*256 + ((length + 4 + 255) & ~255)) / 256`. If that address is at or beyond `stop_pg*256`, the ring size is subtracted.
- R8: The status byte is 0x01, with bit 5 (0x20) also set when bit 0 of the first frame byte is 1. `rx_status` holds the last stored frame's status.
- R9: `rx_done` is a single-cycle pulse on the cycle after the last header write. `cur_pg` takes the next-page value on that same cycle.
- R10: Bytes beyond the 1514th of a frame are not written, and the length counts only the 1514 stored bytes.
- R11: Beats without the first-byte marker while no frame is in progress, and all beats that arrive while padding, header writing or completion is under way, are ignored. This includes a new frame's first byte.
- R12: If `cur_pg` is at or beyond `stop_pg` when a frame is accepted, the frame is placed at `start_pg` instead.
- R13: A cycle with `cur_ld` high loads `cur_ld_pg` into `cur_pg` on the next cycle, unless a frame completes on that same cycle. `cur_pg` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halted | input | 1 | Receiver stopped; new frames refused |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page one past the end of the ring |
| bound_pg | input | 8 | Oldest page still owned by software |
| cur_ld | input | 1 | Load strobe for the current page |
| cur_ld_pg | input | 8 | Value loaded into the current page |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Input byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| cur_pg | output | 8 | Current page register |
| rx_status | output | 8 | Status byte of the last stored frame |
| rx_done | output | 1 | One-cycle frame stored pulse |

## Verification
The hardest situation to reach is a new frame arriving while the previous one is still being padded or having its header filled in. The stimulus creates it by sending a 10-byte frame and starting a second frame on the very next beats, so the second frame falls inside the 50 padding cycles and must leave no trace. The wrap at the stop page needs a frame whose data crosses the ring end and whose next-page sum also wraps. This is reached by loading the current page two pages below the stop page and sending 600 bytes. The space limit is probed by moving the boundary so that exactly five and then exactly six pages are free.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_PAD,
      ST_HDR,
      ST_DONE
   } rxw_state_e;

   localparam int HDR_BYTES = 4;
   localparam int CRC_BYTES = 4;
   localparam logic [7:0] STAT_GOOD  = 8'h01;
   localparam logic [7:0] STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
   parameter int PAGE_W     = 8,
   parameter int NEED_BYTES = 1518
) (
   input  logic [PAGE_W-1:0] start_pg,
   input  logic [PAGE_W-1:0] stop_pg,
   input  logic [PAGE_W-1:0] bound_pg,
   input  logic [PAGE_W-1:0] cur_pg,
   output logic              room_ok
);
   localparam int SW      = PAGE_W + 2;
   localparam int NEED_PG = (NEED_BYTES + 255) / 256;
   localparam logic signed [SW-1:0] NEED_V = NEED_PG[SW-1:0];

   logic signed [SW-1:0] s_start, s_stop, s_bound, s_cur, free_pg;
   logic ring_ok;

   always_comb begin
      s_start = $signed(SW'(start_pg));
      s_stop  = $signed(SW'(stop_pg));
      s_bound = $signed(SW'(bound_pg));
      s_cur   = $signed(SW'(cur_pg));
      ring_ok = stop_pg > start_pg;
      if (s_cur < s_bound)
         free_pg = s_bound - s_cur;
      else
         free_pg = (s_stop - s_start) - (s_cur - s_bound);
      room_ok = ring_ok && (free_pg >= NEED_V);
   end
endmodule

// File: rtl/rxr_link_calc.sv
module rxr_link_calc #(
   parameter int PAGE_W    = 8,
   parameter int LEN_W     = 16,
   parameter int CRC_BYTES = 4
) (
   input  logic [PAGE_W-1:0] base_pg,
   input  logic [LEN_W-1:0]  tot_len,
   input  logic [PAGE_W-1:0] start_pg,
   input  logic [PAGE_W-1:0] stop_pg,
   output logic [PAGE_W-1:0] next_pg
);
   localparam int W2 = PAGE_W + LEN_W;

   logic [LEN_W:0] span_b;
   logic [W2-1:0]  step_pg, raw_pg, fixed_pg;

   always_comb begin
      span_b  = {1'b0, tot_len} + (LEN_W+1)'(CRC_BYTES + 255);
      step_pg = W2'(span_b >> 8);
      raw_pg  = W2'(base_pg) + step_pg;
      if (raw_pg >= W2'(stop_pg))
         fixed_pg = raw_pg - (W2'(stop_pg) - W2'(start_pg));
      else
         fixed_pg = raw_pg;
      next_pg = PAGE_W'(fixed_pg);
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
   parameter int PAGE_W    = 8,
   parameter int LEN_W     = 16,
   parameter int MAX_FRAME = 1514,
   parameter int MIN_FRAME = 60
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                halted,
   input  logic [PAGE_W-1:0]   start_pg,
   input  logic [PAGE_W-1:0]   stop_pg,
   input  logic [PAGE_W-1:0]   bound_pg,
   input  logic                cur_ld,
   input  logic [PAGE_W-1:0]   cur_ld_pg,
   input  logic                in_valid,
   input  logic                in_sof,
   input  logic                in_eof,
   input  logic [7:0]          in_data,
   output logic                mem_we,
   output logic [PAGE_W+7:0]   mem_addr,
   output logic [7:0]          mem_wdata,
   output logic [PAGE_W-1:0]   cur_pg,
   output logic [7:0]          rx_status,
   output logic                rx_done
);
   import rxr_pkg::*;

   localparam int ADDR_W     = PAGE_W + 8;
   localparam int NEED_BYTES = MAX_FRAME + CRC_BYTES;

   if (PAGE_W > 8) begin : g_err_page
      $error("PAGE_W must not exceed 8, the header carries one page byte");
   end
   if (LEN_W > 16 || (MAX_FRAME + 8) >= (1 << LEN_W)) begin : g_err_len
      $error("LEN_W must hold the largest length and fit the two header bytes");
   end
   if (MIN_FRAME > MAX_FRAME) begin : g_err_min
      $error("MIN_FRAME must not exceed MAX_FRAME");
   end

   rxw_state_e          state_q;
   logic [ADDR_W-1:0]   wptr_q;
   logic [LEN_W-1:0]    cnt_q;
   logic [PAGE_W-1:0]   base_pg_q;
   logic [1:0]          hidx_q;
   logic                group_q;
   logic                we_q, done_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [7:0]          wdata_q;
   logic [PAGE_W-1:0]   cur_q;
   logic [7:0]          stat_q;

   logic [ADDR_W-1:0]   start_a, stop_a, first_a, data0_a;
   logic [PAGE_W-1:0]   first_pg, next_pg;
   logic                room_ok, keep_byte, short_first, short_next;
   logic [LEN_W-1:0]    cnt_nxt, tot_len;
   logic [7:0]          stat_byte, hdr_byte;
   logic [15:0]         len16;

   assign start_a  = {start_pg, 8'h00};
   assign stop_a   = {stop_pg, 8'h00};
   assign first_pg = (cur_q >= stop_pg) ? start_pg : cur_q;
   assign first_a  = {first_pg, 8'h00};
   assign data0_a  = first_a + ADDR_W'(HDR_BYTES);

   assign keep_byte = cnt_q < LEN_W'(MAX_FRAME);
   assign cnt_nxt   = cnt_q + LEN_W'(keep_byte);
   assign tot_len   = cnt_q + LEN_W'(HDR_BYTES);
   assign len16     = 16'(tot_len);
   assign stat_byte = STAT_GOOD | (group_q ? STAT_GROUP : 8'h00);

   if (MIN_FRAME > 1) begin : g_pad
      assign short_first = 1'b1;
      assign short_next  = cnt_nxt < LEN_W'(MIN_FRAME);
   end else begin : g_nopad
      assign short_first = 1'b0;
      assign short_next  = 1'b0;
   end

   rxr_space_chk #(
      .PAGE_W    (PAGE_W),
      .NEED_BYTES(NEED_BYTES)
   ) u_space (
      .start_pg(start_pg),
      .stop_pg (stop_pg),
      .bound_pg(bound_pg),
      .cur_pg  (cur_q),
      .room_ok (room_ok)
   );

   rxr_link_calc #(
      .PAGE_W   (PAGE_W),
      .LEN_W    (LEN_W),
      .CRC_BYTES(CRC_BYTES)
   ) u_link (
      .base_pg (base_pg_q),
      .tot_len (tot_len),
      .start_pg(start_pg),
      .stop_pg (stop_pg),
      .next_pg (next_pg)
   );

   function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] lo,
                                                   input logic [ADDR_W-1:0] hi);
      logic [ADDR_W-1:0] a1;
      a1 = a + ADDR_W'(1);
      return (a1 == hi) ? lo : a1;
   endfunction

   always_comb begin
      case (hidx_q)
         2'd0:    hdr_byte = stat_byte;
         2'd1:    hdr_byte = 8'(next_pg);
         2'd2:    hdr_byte = len16[7:0];
         default: hdr_byte = len16[15:8];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         wptr_q    <= '0;
         cnt_q     <= '0;
         base_pg_q <= '0;
         hidx_q    <= '0;
         group_q   <= 1'b0;
         we_q      <= 1'b0;
         done_q    <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         cur_q     <= '0;
         stat_q    <= '0;
      end else begin
         we_q   <= 1'b0;
         done_q <= 1'b0;
         if (cur_ld) cur_q <= cur_ld_pg;
         case (state_q)
            ST_IDLE: begin
               if (in_valid && in_sof && !halted && room_ok) begin
                  we_q      <= 1'b1;
                  addr_q    <= data0_a;
                  wdata_q   <= in_data;
                  wptr_q    <= step_addr(data0_a, start_a, stop_a);
                  cnt_q     <= LEN_W'(1);
                  group_q   <= in_data[0];
                  base_pg_q <= first_pg;
                  hidx_q    <= '0;
                  if (!in_eof)          state_q <= ST_DATA;
                  else if (short_first) state_q <= ST_PAD;
                  else                  state_q <= ST_HDR;
               end
            end
            ST_DATA: begin
               if (in_valid) begin
                  if (keep_byte) begin
                     we_q    <= 1'b1;
                     addr_q  <= wptr_q;
                     wdata_q <= in_data;
                     wptr_q  <= step_addr(wptr_q, start_a, stop_a);
                  end
                  cnt_q <= cnt_nxt;
                  if (in_eof) state_q <= short_next ? ST_PAD : ST_HDR;
               end
            end
            ST_PAD: begin
               we_q    <= 1'b1;
               addr_q  <= wptr_q;
               wdata_q <= 8'h00;
               wptr_q  <= step_addr(wptr_q, start_a, stop_a);
               cnt_q   <= cnt_q + LEN_W'(1);
               if (cnt_q + LEN_W'(1) >= LEN_W'(MIN_FRAME)) state_q <= ST_HDR;
            end
            ST_HDR: begin
               we_q    <= 1'b1;
               addr_q  <= {base_pg_q, 6'b0, hidx_q};
               wdata_q <= hdr_byte;
               hidx_q  <= hidx_q + 2'd1;
               if (hidx_q == 2'd3) state_q <= ST_DONE;
            end
            ST_DONE: begin
               done_q  <= 1'b1;
               cur_q   <= next_pg;
               stat_q  <= stat_byte;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_we    = we_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign cur_pg    = cur_q;
   assign rx_status = stat_q;
   assign rx_done   = done_q;
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
   parameter int PAGE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_we,
   input logic [PAGE_W+7:0] mem_addr,
   input logic [PAGE_W-1:0] start_pg,
   input logic [PAGE_W-1:0] stop_pg,
   input logic              cur_ld,
   input logic [PAGE_W-1:0] cur_ld_pg,
   input logic [PAGE_W-1:0] cur_pg,
   input logic [7:0]        rx_status,
   input logic              rx_done
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R9
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> (!mem_we && $past(mem_we)));

   // R8
   status_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> rx_status[0]);

   // R4
   addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr >= {start_pg, 8'h00} && mem_addr < {stop_pg, 8'h00}));

   // R13
   cur_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_ld |=> (rx_done || cur_pg == $past(cur_ld_pg)));
endmodule

bind rx_ring_writer rxr_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .start_pg (start_pg),
   .stop_pg  (stop_pg),
   .cur_ld   (cur_ld),
   .cur_ld_pg(cur_ld_pg),
   .cur_pg   (cur_pg),
   .rx_status(rx_status),
   .rx_done  (rx_done)
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
   localparam int CLK_P = 10;
   localparam int WD_LIMIT = 150000;

   typedef logic [7:0] u8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halted = 1'b0;
   logic [7:0] start_pg = 8'h40, stop_pg = 8'h60, bound_pg = 8'h40;
   logic cur_ld = 1'b0;
   logic [7:0] cur_ld_pg = 8'h00;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic mem_we;
   logic [15:0] mem_addr;
   logic [7:0] mem_wdata, cur_pg, rx_status;
   logic rx_done;

   int total = 0, bad = 0;
   int exp_a[$], exp_d[$];
   int exp_cur = 0, exp_stat = 0, exp_dones = 0, seen_dones = 0;
   int cyc = 0;
   bit prev_we = 0;
   bit finished = 0;
   string tag = "R4";
   u8 fr[$], fr2[$];

   always #(CLK_P/2) clk = ~clk;

   rx_ring_writer u_dut (
      .clk(clk), .rst_n(rst_n), .halted(halted),
      .start_pg(start_pg), .stop_pg(stop_pg), .bound_pg(bound_pg),
      .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .cur_pg(cur_pg), .rx_status(rx_status), .rx_done(rx_done)
   );

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, exp);
      end
   endtask

   // reference: per-clock comparison of the write port and completion
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_we) begin
            if (exp_a.size() == 0) begin
               chk(0, {tag, " unexpected write addr"}, mem_addr, -1);
            end else begin
               int a, d;
               a = exp_a.pop_front();
               d = exp_d.pop_front();
               chk(mem_addr == a[15:0], {tag, " write addr"}, mem_addr, a);
               chk(mem_wdata == d[7:0], {tag, " write data"}, mem_wdata, d);
            end
         end
         if (rx_done) begin
            seen_dones++;
            chk(prev_we && exp_a.size() == 0, "R9 done timing", prev_we, 1);
            chk(cur_pg == exp_cur[7:0], "R7/R9 cur_pg at done", cur_pg, exp_cur);
            chk(rx_status == exp_stat[7:0], "R8 status", rx_status, exp_stat);
         end
         prev_we = mem_we;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !finished) begin
         finished = 1;
         bad++;
         total++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic void model(input u8 f[$]);
      int sa, so, idx, bnd, avail, n, stored, a, nxt, tl, st;
      sa = start_pg * 256;
      so = stop_pg * 256;
      idx = cur_pg * 256;
      bnd = bound_pg * 256;
      if (halted || stop_pg <= start_pg) return;
      if (idx < bnd) avail = bnd - idx;
      else avail = (so - sa) - (idx - bnd);
      if (avail < 1518) return;
      if (idx >= so) idx = sa;
      n = (f.size() > 1514) ? 1514 : f.size();
      stored = (n < 60) ? 60 : n;
      a = idx + 4;
      for (int k = 0; k < stored; k++) begin
         exp_a.push_back(a);
         exp_d.push_back((k < n) ? int'(f[k]) : 0);
         a++;
         if (a == so) a = sa;
      end
      tl = stored + 4;
      nxt = idx + ((tl + 4 + 255) / 256) * 256;
      if (nxt >= so) nxt -= (so - sa);
      st = 1 | (f[0][0] ? 32 : 0);
      exp_a.push_back(idx);     exp_d.push_back(st);
      exp_a.push_back(idx + 1); exp_d.push_back(nxt / 256);
      exp_a.push_back(idx + 2); exp_d.push_back(tl % 256);
      exp_a.push_back(idx + 3); exp_d.push_back(tl / 256);
      exp_cur = nxt / 256;
      exp_stat = st;
      exp_dones++;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic beat(input bit v, input bit s, input bit e, input u8 d);
      in_valid = v; in_sof = s; in_eof = e; in_data = d;
      tick();
   endtask

   task automatic mk(ref u8 q[$], input int n, input u8 first);
      q.delete();
      for (int i = 0; i < n; i++) q.push_back((i == 0) ? first : u8'(i * 7 + 3));
   endtask

   task automatic send(input u8 f[$], input bit gaps);
      for (int k = 0; k < f.size(); k++) begin
         beat(1, k == 0, k == f.size() - 1, f[k]);
         if (gaps && (k % 3 == 1)) beat(0, 0, 0, 8'h00);
      end
      beat(0, 0, 0, 8'h00);
   endtask

   task automatic settle(input string t, input int prev_cur);
      repeat (80) tick();
      chk(exp_a.size() == 0, {t, " writes outstanding"}, exp_a.size(), 0);
      chk(seen_dones == exp_dones, {t, " done count"}, seen_dones, exp_dones);
      if (seen_dones == exp_dones && prev_cur >= 0)
         chk(cur_pg == prev_cur[7:0], {t, " cur_pg unchanged"}, cur_pg, prev_cur);
   endtask

   task automatic load_cur(input u8 p);
      cur_ld = 1; cur_ld_pg = p;
      tick();
      cur_ld = 0;
      chk(cur_pg == p, "R13 cur_pg load", cur_pg, p);
   endtask

   initial begin
      repeat (3) tick();
      chk(mem_we == 0, "R4 reset mem_we", mem_we, 0);
      chk(rx_done == 0, "R9 reset rx_done", rx_done, 0);
      chk(cur_pg == 0, "R13 reset cur_pg", cur_pg, 0);
      chk(rx_status == 0, "R8 reset status", rx_status, 0);
      rst_n = 1;
      tick();
      load_cur(8'h40);

      // R4 R6 R7 R8: plain 100-byte unicast frame
      tag = "R6";
      mk(fr, 100, 8'h00); model(fr); send(fr, 0); settle("R6", -1);

      // R5 R8: short group frame with gaps in the stream
      tag = "R5";
      mk(fr, 10, 8'h01); model(fr); send(fr, 1); settle("R5", -1);

      // R11: beats without a start marker while idle
      tag = "R11";
      for (int k = 0; k < 5; k++) beat(1, 0, k == 4, u8'(k));
      beat(0, 0, 0, 0);
      settle("R11 idle", exp_cur);

      // R1: halted
      tag = "R1";
      halted = 1;
      mk(fr, 100, 8'h00); model(fr); send(fr, 0); settle("R1", exp_cur);
      halted = 0;

      // R3: five free pages refuse, six accept (cur is 0x42)
      tag = "R3";
      bound_pg = 8'h47;
      mk(fr, 100, 8'h00); model(fr); send(fr, 0); settle("R3 five pages", exp_cur);
      bound_pg = 8'h48;
      model(fr); send(fr, 0); settle("R3 six pages", -1);

      // R2: stop not above start
      tag = "R2";
      start_pg = 8'h60; stop_pg = 8'h40;
      model(fr); send(fr, 0); settle("R2", exp_cur);
      start_pg = 8'h40; stop_pg = 8'h60;

      // R4 R7: data and next page both wrap
      tag = "R4";
      bound_pg = 8'h50;
      load_cur(8'h5E); exp_cur = 8'h5E;
      mk(fr, 600, 8'h02); model(fr); send(fr, 0); settle("R4 wrap", -1);
      chk(cur_pg == 8'h41, "R7 wrapped next page", cur_pg, 8'h41);

      // R10: oversize frame truncated
      tag = "R10";
      mk(fr, 1600, 8'h00); model(fr); send(fr, 0); settle("R10", -1);
      chk(cur_pg == 8'h47, "R10 next page after cap", cur_pg, 8'h47);

      // R11: second frame starts during padding of the first
      tag = "R11";
      mk(fr, 10, 8'h00); mk(fr2, 5, 8'h01);
      model(fr);
      for (int k = 0; k < 10; k++) beat(1, k == 0, k == 9, fr[k]);
      for (int k = 0; k < 5; k++) beat(1, k == 0, k == 4, fr2[k]);
      beat(0, 0, 0, 0);
      settle("R11 busy", -1);

      // R12: current page at the stop page
      tag = "R12";
      bound_pg = 8'h58;
      load_cur(8'h60); exp_cur = 8'h60;
      mk(fr, 20, 8'h00); model(fr); send(fr, 0); settle("R12", -1);
      chk(cur_pg == 8'h41, "R12 placed at start", cur_pg, 8'h41);

      // R5: single-beat frame
      tag = "R5";
      mk(fr, 1, 8'h03); model(fr); send(fr, 0); settle("R5 single beat", -1);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule